// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two 32-bit two's-complement numbers over several clock cycles. It returns a signed 64-bit product as a high word and a low word. A one-cycle start pulse captures both operands. The multiplier operand goes into the low product register and the high register is cleared. After that, every clock cycle retires two multiplier bits.

In each step a recoder examines the two lowest bits of the low register together with a saved bit from the previous step. It picks a signed multiple of the multiplicand: zero, plus or minus one times, or plus or minus two times. That multiple is added to or subtracted from the high word in an adder that is two bits wider than an operand. The whole high:low pair then shifts right arithmetically by two places. Sixteen steps complete one multiply. A single-cycle done pulse announces the product, which stays on the outputs until the next accepted start.

Top module: `booth4_mult`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and `res_hi` and `res_lo` are both zero.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is high in the following cycle and stays high for exactly 16 cycles.
- R3: `done` is high for exactly one cycle. That cycle is the first one after the last busy cycle, which is 17 cycles after the accepting clock edge.
- R4: In the cycle in which `done` is high, `{res_hi, res_lo}` equals the signed 64-bit product of `op_a` (multiplicand) and `op_b` (multiplier) as they were captured at the accepting edge.
- R5: The most negative operand times itself gives +2^62, and the most negative value times the most positive value gives the correct negative product, with no overflow in the two-bit-wider adder.
- R6: Operands of 0 and -1 (all ones) in either position give the exact signed product: zero, the negated other operand, or +1.
- R7: A `start` pulse while `busy` is 1 is ignored. The running multiply keeps its latency and delivers the product of the first operand pair.
- R8: While `busy` is 0 and no `start` is accepted, `res_hi` and `res_lo` hold their value, whatever `op_a` and `op_b` do.
- R9: A `start` sampled in the same cycle as `done` is accepted. The next product arrives 17 cycles later.
- R10: The recoding of {low[1], low[0], previous bit} applies these multiples: 000 and 111 give 0; 001 and 010 give +1x; 011 gives +2x; 100 gives -2x; 101 and 110 give -1x. The saved bit is 0 at start. Multipliers with repeating bit patterns (0x5555_5555, 0xAAAA_AAAA, 0x3333_3333, 0xCCCC_CCCC, 0x0F0F_0F0F) reach every code and still give the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin a multiply when idle |
| op_a | input | 32 | Multiplicand, two's complement |
| op_b | input | 32 | Multiplier, two's complement |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| res_hi | output | 32 | Upper half of the signed product |
| res_lo | output | 32 | Lower half of the signed product |

## Verification
The collision that matters is a new `start` arriving in the same cycle as the `done` pulse of the previous multiply. The bench provokes it by raising `start` with fresh operands in exactly the cycle where it observes `done` high. It first checks the finished product in that cycle. It then requires that the second multiply is accepted, takes the full 16 busy cycles and produces its own exact product. A second collision, `start` arriving during `busy`, is checked separately: the bench requires it to change neither the latency nor the result.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_TWO  = 2'd2
  } mag_e;

  typedef struct packed {
    logic neg;
    mag_e mag;
  } booth_sel_t;

endpackage

// File: rtl/booth4_recode.sv
module booth4_recode
  import booth4_pkg::*;
(
  input  logic [2:0] triple,
  output booth_sel_t sel
);

  always_comb begin
    sel.neg = 1'b0;
    sel.mag = MAG_ZERO;
    unique case (triple)
      3'b001, 3'b010: begin sel.neg = 1'b0; sel.mag = MAG_ONE; end
      3'b011:         begin sel.neg = 1'b0; sel.mag = MAG_TWO; end
      3'b100:         begin sel.neg = 1'b1; sel.mag = MAG_TWO; end
      3'b101, 3'b110: begin sel.neg = 1'b1; sel.mag = MAG_ONE; end
      default:        begin sel.neg = 1'b0; sel.mag = MAG_ZERO; end
    endcase
  end

endmodule

// File: rtl/booth4_addsub.sv
module booth4_addsub
  import booth4_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int ACCW = OPW + 2
) (
  input  logic [OPW-1:0]  acc_hi,
  input  logic [OPW-1:0]  mcand,
  input  booth_sel_t      sel,
  output logic [ACCW-1:0] sum
);

  localparam int EXT = ACCW - OPW;

  logic [ACCW-1:0] base;
  logic [ACCW-1:0] mc_x1;
  logic [ACCW-1:0] mc_x2;
  logic [ACCW-1:0] multiple;

  assign base  = {{EXT{acc_hi[OPW-1]}}, acc_hi};
  assign mc_x1 = {{EXT{mcand[OPW-1]}}, mcand};
  assign mc_x2 = {mc_x1[ACCW-2:0], 1'b0};

  always_comb begin
    unique case (sel.mag)
      MAG_ONE: multiple = mc_x1;
      MAG_TWO: multiple = mc_x2;
      default: multiple = '0;
    endcase
  end

  assign sum = sel.neg ? (base - multiple) : (base + multiple);

endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl #(
  parameter int STEPS = 16,
  parameter int CNTW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam logic [CNTW-1:0] LAST = CNTW'(STEPS - 1);

  logic [CNTW-1:0] cnt_q;

  assign load = start && !busy;
  assign step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/booth4_mult.sv
module booth4_mult
  import booth4_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic           busy,
  output logic           done,
  output logic [OPW-1:0] res_hi,
  output logic [OPW-1:0] res_lo
);

  localparam int ACCW  = OPW + 2;
  localparam int STEPS = OPW / 2;

  logic            load;
  logic            step;
  logic [OPW-1:0]  hi_q;
  logic [OPW-1:0]  lo_q;
  logic [OPW-1:0]  mcand_q;
  logic            prev_q;
  booth_sel_t      sel;
  logic [ACCW-1:0] sum;

  booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  booth4_recode u_recode (
    .triple ({lo_q[1:0], prev_q}),
    .sel    (sel)
  );

  booth4_addsub #(.OPW(OPW), .ACCW(ACCW)) u_addsub (
    .acc_hi (hi_q),
    .mcand  (mcand_q),
    .sel    (sel),
    .sum    (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
      prev_q  <= 1'b0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= op_b;
      mcand_q <= op_a;
      prev_q  <= 1'b0;
    end else if (step) begin
      hi_q    <= sum[ACCW-1:2];
      lo_q    <= {sum[1:0], lo_q[OPW-1:2]};
      prev_q  <= lo_q[1];
    end
  end

  assign res_hi = hi_q;
  assign res_lo = lo_q;

endmodule

// File: rtl/booth4_mult_chk.sv
module booth4_mult_chk #(
  parameter int OPW   = 32,
  parameter int STEPS = OPW / 2,
  parameter int RW    = $clog2(STEPS + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [OPW-1:0] res_hi,
  input logic [OPW-1:0] res_lo,
  input logic [OPW-1:0] mcand_q
);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                run_q <= '0;
    else if (start && !busy) run_q <= '0;
    else if (busy)          run_q <= run_q + 1'b1;
  end

  AST_BUSY_RISES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy) else $error("busy not raised");              // R2
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < RW'(STEPS))) else $error("busy too long");           // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle");            // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && run_q == RW'(STEPS))) else $error("done misplaced"); // R3
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(mcand_q)) else $error("operand reloaded"); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo)))
    else $error("result moved while idle");                                // R8

endmodule

bind booth4_mult booth4_mult_chk #(.OPW(OPW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .res_hi  (res_hi),
  .res_lo  (res_lo),
  .mcand_q (mcand_q)
);

// File: tb/booth4_mult_tb.sv
`timescale 1ns/1ps
module booth4_mult_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy;
  logic        done;
  logic [31:0] res_hi;
  logic [31:0] res_lo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  booth4_mult u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb;
    sa = $signed({{32{a[31]}}, a});
    sb = $signed({{32{b[31]}}, b});
    return 64'(sa * sb);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves start low at the negedge after the accepting edge.
  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    start = 1'b1; op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Returns the number of negedges until done is seen (expected 16).
  task automatic wait_done(output int lat);
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
  endtask

  task automatic run_one(input string req, input logic [31:0] a, input logic [31:0] b);
    int lat;
    launch(a, b);
    check("R2 busy after start", 64'(busy), 64'd1);
    wait_done(lat);
    check("R3 latency", 64'(lat), 64'd16);
    check(req, {res_hi, res_lo}, ref_mul(a, b));
    @(negedge clk);
    check("R3 done single", 64'(done), 64'd0);
  endtask

  task automatic test_reset();
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 result", {res_hi, res_lo}, 64'd0);
  endtask

  task automatic test_corners();
    run_one("R5 min*min", 32'h8000_0000, 32'h8000_0000);
    run_one("R5 max*min", 32'h7FFF_FFFF, 32'h8000_0000);
    run_one("R5 min*max", 32'h8000_0000, 32'h7FFF_FFFF);
    run_one("R6 -1*-1", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_one("R6 -1*x", 32'hFFFF_FFFF, 32'h1234_5678);
    run_one("R6 x*-1", 32'h8765_4321, 32'hFFFF_FFFF);
    run_one("R6 0*x", 32'h0, 32'hDEAD_BEEF);
    run_one("R6 x*0", 32'hCAFE_F00D, 32'h0);
  endtask

  task automatic test_patterns();
    run_one("R10 5555", 32'h1357_9BDF, 32'h5555_5555);
    run_one("R10 AAAA", 32'hF00D_1234, 32'hAAAA_AAAA);
    run_one("R10 3333", 32'h8000_0001, 32'h3333_3333);
    run_one("R10 CCCC", 32'h7654_3210, 32'hCCCC_CCCC);
    run_one("R10 0F0F", 32'hFFFF_FFFE, 32'h0F0F_0F0F);
  endtask

  task automatic test_random();
    for (int i = 0; i < 20; i++) run_one("R4 random", $urandom, $urandom);
  endtask

  task automatic test_start_busy();
    int lat;
    launch(32'h0000_1234, 32'hFFFF_0F00);
    repeat (4) @(negedge clk);
    start = 1'b1; op_a = 32'h7777_7777; op_b = 32'h3; // R7: ignored
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check("R7 latency kept", 64'(lat), 64'd11);
    check("R7 first product", {res_hi, res_lo}, ref_mul(32'h0000_1234, 32'hFFFF_0F00));
  endtask

  task automatic test_hold();
    logic [63:0] snap;
    run_one("R4 before hold", 32'hABCD_0123, 32'h0456_789A);
    snap = {res_hi, res_lo};
    for (int i = 0; i < 8; i++) begin
      op_a = $urandom; op_b = $urandom;
      @(negedge clk);
    end
    check("R8 result held", {res_hi, res_lo}, snap);
    check("R8 stays idle", 64'(busy), 64'd0);
  endtask

  task automatic test_back_to_back();
    int lat;
    launch(32'hFFFF_8001, 32'h0001_FFFF);
    wait_done(lat);
    check("R9 first product", {res_hi, res_lo}, ref_mul(32'hFFFF_8001, 32'h0001_FFFF));
    launch(32'h4000_0003, 32'hC000_0005); // R9: start in the done cycle
    check("R9 accepted", 64'(busy), 64'd1);
    wait_done(lat);
    check("R9 latency", 64'(lat), 64'd16);
    check("R9 second product", {res_hi, res_lo}, ref_mul(32'h4000_0003, 32'hC000_0005));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_corners();
    test_patterns();
    test_random();
    test_start_busy();
    test_hold();
    test_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule